// File: doc/BRIEF.md
# Exception Escalation and Delivery Controller

This block sequences the delivery of processor exceptions. A request carries a vector number and an error code. The controller first reloads the instruction pointer from the saved copy. It then reads the vector entry from the interrupt table and pushes the stack frame one word at a time through a request/acknowledge push port. When the vector carries an error code and protected mode is on, that code is pushed as the final word. On completion it reports the handler selector, the handler offset and whether the interrupt-enable flag must be cleared.

A fault that arrives while a delivery is in progress abandons that delivery. The nesting depth then rises by one. At depth two the delivery restarts with the double-fault vector (8) and an error code of zero. At depth three no delivery takes place: the controller issues a one-cycle processor reset request instead. The depth returns to zero only when a delivery finishes without a new fault.

The controller holds the operating mode, flags, code selector and restored instruction pointer fixed for the length of one delivery attempt. They are captured again each time a fault restarts the sequence.

Top module: `exc_deliver_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `vec_rd_req`, `push_req`, `ip_restore`, `dlv_done` and `cpu_reset` are all 0.
- R2: An accepted request, or a restart after a fault, produces a one-cycle `ip_restore` pulse carrying `saved_ip`. In that same cycle the vector read starts at `tbl_base + 4*n` in real mode or `tbl_base + 8*n` in protected mode, where n is the vector being delivered.
- R3: In real mode the entry's bits [15:0] become the handler offset (zero-extended) and bits [31:16] become the handler selector, and `clear_if` is 1.
- R4: In protected mode the gate type is bits [43:40] and the selector is bits [31:16]. Type bit 43 set selects a 32-bit gate, with offset {bits[63:48], bits[15:0]}; clear selects a 16-bit gate, with offset bits[15:0] zero-extended. Type bit 40 = 0 (interrupt gate) sets `clear_if`, and 1 (trap gate) clears it.
- R5: The frame is pushed as flags, then code selector (zero-extended), then restored instruction pointer. Each word is held stable on `push_data` with `push_req` high until `push_ack`.
- R6: An error code is pushed as a fourth word only if the mode is protected and the vector is 8, 10, 11, 12, 13, 14 or 17.
- R7: A `fault` while busy abandons the current attempt and restarts delivery with vector 8 and error code 0.
- R8: The second fault within one nested sequence (depth three) delivers nothing. It gives a single `cpu_reset` pulse and returns the controller to idle.
- R9: The nesting depth clears after a completed delivery and after a reset pulse, so the next request with one fault ends in a double fault, not a reset.
- R10: A `fault` in the same cycle as the `push_ack` of the final word wins: there is no `dlv_done`, and the sequence escalates.
- R11: `exc_req` while busy is ignored: the vector and the frame of the delivery in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request, taken when idle |
| exc_vec | input | VW | Requested vector number |
| exc_err | input | DW | Error code of the request |
| fault | input | 1 | Fault raised during delivery |
| prot_mode | input | 1 | Protected mode enabled |
| saved_ip | input | DW | Saved instruction pointer |
| cur_flags | input | DW | Current flags word |
| cur_cs | input | SW | Current code selector |
| tbl_base | input | AW | Vector table base address |
| vec_rd_req | output | 1 | Vector entry read request |
| vec_rd_addr | output | AW | Vector entry address |
| vec_rd_valid | input | 1 | Vector entry data valid |
| vec_rd_data | input | 4*SW | Vector entry contents |
| push_req | output | 1 | Stack push request |
| push_data | output | DW | Word to push |
| push_ack | input | 1 | Push accepted |
| ip_restore | output | 1 | Pulse: reload instruction pointer |
| ip_restore_val | output | DW | Value to reload |
| dlv_done | output | 1 | Pulse: delivery completed |
| dlv_vec | output | VW | Vector that was delivered |
| handler_cs | output | SW | Handler code selector |
| handler_ip | output | DW | Handler offset |
| clear_if | output | 1 | Interrupt-enable flag must be cleared |
| cpu_reset | output | 1 | Pulse: nested-fault reset |
| busy | output | 1 | Delivery in progress |

## Verification
The acknowledge of a pushed word and a new fault can land in the same cycle. The bench provokes this by raising `fault` together with `push_ack` on a chosen push, including the final error-code push and the first push of an already escalated attempt. A fault on the final push must yield a restart at vector 8 with no completion pulse. A second fault must yield a reset pulse with no delivery. These outcomes are judged from the count of restore pulses, the words pushed in the last attempt, and whether `dlv_done` or `cpu_reset` appears.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_PUSH_ERR
    } dstate_t;

    // vectors whose frame ends with an error code word
    function automatic logic exc_carries_err(input logic [7:0] v);
        case (v)
            8'd8, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd17: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // gate type bit positions inside the type nibble
    localparam int GT_WIDE_BIT = 3;
    localparam int GT_TRAP_BIT = 0;

endpackage

// File: rtl/exc_nest_track.sv
module exc_nest_track #(
    parameter int NEST_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bump,
    input  logic clear,
    output logic escalate,
    output logic give_up
);
    localparam int LW = $clog2(NEST_LIMIT + 1);

    logic [LW-1:0] level;
    logic [LW-1:0] nxt;

    always_comb begin
        nxt      = level + LW'(1);
        escalate = (nxt > LW'(1));
        give_up  = (nxt >= LW'(NEST_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else if (bump) begin
            level <= give_up ? '0 : nxt;
        end else if (clear) begin
            level <= '0;
        end
    end
endmodule

// File: rtl/exc_gate_decode.sv
module exc_gate_decode #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 16,
    parameter int VW = 8
) (
    input  logic            pm,
    input  logic [AW-1:0]   base,
    input  logic [VW-1:0]   vec,
    input  logic [4*SW-1:0] entry,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   h_ip,
    output logic [SW-1:0]   h_cs,
    output logic            h_clr_if
);
    import exc_pkg::*;

    localparam int TYPE_LO = 2*SW + 8;

    logic [3:0]    gtype;
    logic [SW-1:0] off_lo;
    logic [SW-1:0] off_hi;

    always_comb begin
        gtype  = entry[TYPE_LO +: 4];
        off_lo = entry[SW-1:0];
        off_hi = entry[4*SW-1:3*SW];
        h_cs   = entry[2*SW-1:SW];
        addr   = base + (AW'(vec) << (pm ? 3 : 2));
        if (pm && gtype[GT_WIDE_BIT]) begin
            h_ip = DW'({off_hi, off_lo});
        end else begin
            h_ip = DW'(off_lo);
        end
        h_clr_if = !pm || !gtype[GT_TRAP_BIT];
    end
endmodule

// File: rtl/exc_frame_sel.sv
module exc_frame_sel #(
    parameter int DW = 32,
    parameter int SW = 16
) (
    input  exc_pkg::dstate_t st,
    input  logic [DW-1:0]    flags,
    input  logic [SW-1:0]    cs,
    input  logic [DW-1:0]    ip,
    input  logic [DW-1:0]    err,
    output logic             req,
    output logic [DW-1:0]    data
);
    import exc_pkg::*;

    always_comb begin
        req  = 1'b1;
        data = '0;
        case (st)
            ST_PUSH_FL:  data = flags;
            ST_PUSH_CS:  data = DW'(cs);
            ST_PUSH_IP:  data = ip;
            ST_PUSH_ERR: data = err;
            default:     req  = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_deliver_ctrl.sv
module exc_deliver_ctrl #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int SW         = 16,
    parameter int VW         = 8,
    parameter int NEST_LIMIT = 3,
    parameter int DF_VEC     = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_req,
    input  logic [VW-1:0]   exc_vec,
    input  logic [DW-1:0]   exc_err,
    input  logic            fault,
    input  logic            prot_mode,
    input  logic [DW-1:0]   saved_ip,
    input  logic [DW-1:0]   cur_flags,
    input  logic [SW-1:0]   cur_cs,
    input  logic [AW-1:0]   tbl_base,
    output logic            vec_rd_req,
    output logic [AW-1:0]   vec_rd_addr,
    input  logic            vec_rd_valid,
    input  logic [4*SW-1:0] vec_rd_data,
    output logic            push_req,
    output logic [DW-1:0]   push_data,
    input  logic            push_ack,
    output logic            ip_restore,
    output logic [DW-1:0]   ip_restore_val,
    output logic            dlv_done,
    output logic [VW-1:0]   dlv_vec,
    output logic [SW-1:0]   handler_cs,
    output logic [DW-1:0]   handler_ip,
    output logic            clear_if,
    output logic            cpu_reset,
    output logic            busy
);
    import exc_pkg::*;

    dstate_t       state;
    logic [VW-1:0] cur_vec;
    logic [DW-1:0] cur_err;
    logic [DW-1:0] cap_flags;
    logic [SW-1:0] cap_cs;
    logic          cap_pm;

    logic          start_new;
    logic          refault;
    logic          bump;
    logic          escalate;
    logic          give_up;
    logic          need_err;
    logic          finish;

    logic [DW-1:0] dec_ip;
    logic [SW-1:0] dec_cs;
    logic          dec_clr;

    always_comb begin
        busy      = (state != ST_IDLE);
        start_new = !busy && exc_req;
        refault   = busy && fault;
        bump      = start_new || refault;
        need_err  = cap_pm && exc_carries_err(8'(cur_vec));
        finish    = push_ack && !fault &&
                    ((state == ST_PUSH_IP && !need_err) || state == ST_PUSH_ERR);
        vec_rd_req = (state == ST_FETCH);
    end

    exc_nest_track #(.NEST_LIMIT(NEST_LIMIT)) u_nest (
        .clk      (clk),
        .rst      (rst),
        .bump     (bump),
        .clear    (finish),
        .escalate (escalate),
        .give_up  (give_up)
    );

    exc_gate_decode #(.AW(AW), .DW(DW), .SW(SW), .VW(VW)) u_gate (
        .pm       (cap_pm),
        .base     (tbl_base),
        .vec      (cur_vec),
        .entry    (vec_rd_data),
        .addr     (vec_rd_addr),
        .h_ip     (dec_ip),
        .h_cs     (dec_cs),
        .h_clr_if (dec_clr)
    );

    exc_frame_sel #(.DW(DW), .SW(SW)) u_frame (
        .st    (state),
        .flags (cap_flags),
        .cs    (cap_cs),
        .ip    (ip_restore_val),
        .err   (cur_err),
        .req   (push_req),
        .data  (push_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_IDLE;
            cur_vec        <= '0;
            cur_err        <= '0;
            cap_flags      <= '0;
            cap_cs         <= '0;
            cap_pm         <= 1'b0;
            ip_restore     <= 1'b0;
            ip_restore_val <= '0;
            dlv_done       <= 1'b0;
            dlv_vec        <= '0;
            handler_cs     <= '0;
            handler_ip     <= '0;
            clear_if       <= 1'b0;
            cpu_reset      <= 1'b0;
        end else begin
            ip_restore <= 1'b0;
            dlv_done   <= 1'b0;
            cpu_reset  <= 1'b0;
            if (bump) begin
                if (give_up) begin
                    state     <= ST_IDLE;
                    cpu_reset <= 1'b1;
                end else begin
                    state          <= ST_FETCH;
                    ip_restore     <= 1'b1;
                    ip_restore_val <= saved_ip;
                    cap_flags      <= cur_flags;
                    cap_cs         <= cur_cs;
                    cap_pm         <= prot_mode;
                    cur_vec        <= escalate ? VW'(DF_VEC) : exc_vec;
                    cur_err        <= escalate ? '0 : exc_err;
                end
            end else begin
                case (state)
                    ST_FETCH: if (vec_rd_valid) begin
                        handler_ip <= dec_ip;
                        handler_cs <= dec_cs;
                        clear_if   <= dec_clr;
                        dlv_vec    <= cur_vec;
                        state      <= ST_PUSH_FL;
                    end
                    ST_PUSH_FL: if (push_ack) state <= ST_PUSH_CS;
                    ST_PUSH_CS: if (push_ack) state <= ST_PUSH_IP;
                    ST_PUSH_IP: if (push_ack) begin
                        state <= need_err ? ST_PUSH_ERR : ST_IDLE;
                    end
                    ST_PUSH_ERR: if (push_ack) state <= ST_IDLE;
                    default: ;
                endcase
                if (finish) dlv_done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_deliver_chk.sv
module exc_deliver_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          fault,
    input logic          vec_rd_req,
    input logic          push_req,
    input logic [DW-1:0] push_data,
    input logic          push_ack,
    input logic          ip_restore,
    input logic          dlv_done,
    input logic          cpu_reset,
    input logic          busy
);
    // R5: never read the table and push in the same cycle
    assert_fetch_push_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(vec_rd_req && push_req));

    // R5: an unacknowledged word stays put
    assert_push_hold_R5: assert property (@(posedge clk) disable iff (rst)
        push_req && !push_ack && !fault |=> push_req && $stable(push_data));

    // R2: a restore pulse coincides with the vector read
    assert_restore_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        ip_restore |-> vec_rd_req);

    // R7: a fault while busy restarts or resets
    assert_fault_restart_R7: assert property (@(posedge clk) disable iff (rst)
        busy && fault |=> ip_restore || cpu_reset);

    // R8: reset pulse leaves the block idle with no completion
    assert_reset_idle_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_reset |-> !busy && !dlv_done);

    // R10: completion follows a clean acknowledge
    assert_done_clean_R10: assert property (@(posedge clk) disable iff (rst)
        dlv_done |-> $past(push_ack) && !$past(fault) && !busy);
endmodule

bind exc_deliver_ctrl exc_deliver_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fault      (fault),
    .vec_rd_req (vec_rd_req),
    .push_req   (push_req),
    .push_data  (push_data),
    .push_ack   (push_ack),
    .ip_restore (ip_restore),
    .dlv_done   (dlv_done),
    .cpu_reset  (cpu_reset),
    .busy       (busy)
);

// File: tb/tb_exc_deliver_ctrl.sv
`timescale 1ns/1ps
module tb_exc_deliver_ctrl;

    localparam logic [31:0] FLAGS = 32'h0000_0202;
    localparam logic [15:0] CSV   = 16'h1234;
    localparam logic [31:0] SIP   = 32'h0000_4000;
    localparam logic [31:0] BASE  = 32'h0010_0000;
    localparam logic [63:0] G_RM  = 64'h0000_0000_F000_E123;
    localparam logic [63:0] G_I32 = 64'hC001_8E00_0008_2345;
    localparam logic [63:0] G_T32 = 64'hC001_8F00_0008_2345;
    localparam logic [63:0] G_I16 = 64'hC001_8600_0008_2345;
    localparam logic [63:0] G_T16 = 64'hC001_8700_0008_2345;

    typedef struct packed {
        logic        pm;
        logic [7:0]  vec;
        logic [63:0] g;
        logic [7:0]  f0;
        logic [31:0] eip;
        logic [15:0] ecs;
        logic        eclr;
        logic [3:0]  enp;
        logic [7:0]  evec;
    } tv_t;

    localparam int NTV = 10;
    localparam tv_t TV [NTV] = '{
        '{1'b0, 8'd13, G_RM,  8'hFF, 32'h0000_E123, 16'hF000, 1'b1, 4'd3, 8'd13},
        '{1'b1, 8'd13, G_I32, 8'hFF, 32'hC001_2345, 16'h0008, 1'b1, 4'd4, 8'd13},
        '{1'b1, 8'd3,  G_T32, 8'hFF, 32'hC001_2345, 16'h0008, 1'b0, 4'd3, 8'd3},
        '{1'b1, 8'd14, G_I16, 8'hFF, 32'h0000_2345, 16'h0008, 1'b1, 4'd4, 8'd14},
        '{1'b1, 8'd17, G_T16, 8'hFF, 32'h0000_2345, 16'h0008, 1'b0, 4'd4, 8'd17},
        '{1'b1, 8'd9,  G_I32, 8'hFF, 32'hC001_2345, 16'h0008, 1'b1, 4'd3, 8'd9},
        '{1'b1, 8'd10, G_I32, 8'hFF, 32'hC001_2345, 16'h0008, 1'b1, 4'd4, 8'd10},
        '{1'b1, 8'd0,  G_I32, 8'd1,  32'hC001_2345, 16'h0008, 1'b1, 4'd4, 8'd8},
        '{1'b0, 8'd14, G_RM,  8'd0,  32'h0000_E123, 16'hF000, 1'b1, 4'd3, 8'd8},
        '{1'b1, 8'd11, G_T32, 8'd3,  32'hC001_2345, 16'h0008, 1'b0, 4'd4, 8'd8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 1'b0;
    logic [7:0]  exc_vec = '0;
    logic [31:0] exc_err = '0;
    logic        fault = 1'b0;
    logic        prot_mode = 1'b0;
    logic        vec_rd_valid = 1'b0;
    logic [63:0] vec_rd_data = '0;
    logic        push_ack = 1'b0;
    logic        vec_rd_req, push_req, ip_restore, dlv_done, clear_if, cpu_reset, busy;
    logic [31:0] vec_rd_addr, push_data, ip_restore_val, handler_ip;
    logic [7:0]  dlv_vec;
    logic [15:0] handler_cs;

    always #5 clk = ~clk;

    exc_deliver_ctrl dut (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_vec(exc_vec), .exc_err(exc_err),
        .fault(fault), .prot_mode(prot_mode), .saved_ip(SIP), .cur_flags(FLAGS),
        .cur_cs(CSV), .tbl_base(BASE), .vec_rd_req(vec_rd_req), .vec_rd_addr(vec_rd_addr),
        .vec_rd_valid(vec_rd_valid), .vec_rd_data(vec_rd_data), .push_req(push_req),
        .push_data(push_data), .push_ack(push_ack), .ip_restore(ip_restore),
        .ip_restore_val(ip_restore_val), .dlv_done(dlv_done), .dlv_vec(dlv_vec),
        .handler_cs(handler_cs), .handler_ip(handler_ip), .clear_if(clear_if),
        .cpu_reset(cpu_reset), .busy(busy)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] pw [8];
    int          np, nrest, rest_bad;
    logic        got_done, got_reset;
    logic [31:0] last_addr;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic pm_i, input logic [7:0] vec_i, input logic [63:0] g_i,
                            input int f0, input int f1, input logic slow, input logic pester);
        int gpush = 0;
        int hold  = 0;
        np = 0; nrest = 0; rest_bad = 0; got_done = 0; got_reset = 0; last_addr = '0;
        @(negedge clk);
        prot_mode = pm_i; exc_vec = vec_i; exc_err = 32'hC0DE_0000 | 32'(vec_i);
        exc_req = 1'b1;
        @(negedge clk);
        exc_req = 1'b0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            vec_rd_valid = 1'b0; push_ack = 1'b0; fault = 1'b0;
            exc_req = pester && busy;
            if (pester) exc_vec = 8'd5;
            if (ip_restore) begin
                nrest++; np = 0;
                if (ip_restore_val !== SIP) rest_bad++;
            end
            if (dlv_done) begin got_done = 1'b1; break; end
            if (cpu_reset) begin got_reset = 1'b1; break; end
            if (vec_rd_req) begin
                vec_rd_valid = 1'b1; vec_rd_data = g_i; last_addr = vec_rd_addr;
            end
            if (push_req) begin
                if (slow && hold == 0) begin
                    hold = 1;
                end else begin
                    hold = 0; push_ack = 1'b1;
                    if (np < 8) pw[np] = push_data;
                    np++;
                    if (gpush == f0 || gpush == f1) fault = 1'b1;
                    gpush++;
                end
            end
            @(negedge clk);
        end
        vec_rd_valid = 1'b0; push_ack = 1'b0; fault = 1'b0; exc_req = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!busy && !vec_rd_req && !push_req && !ip_restore && !dlv_done && !cpu_reset,
            "R1", "outputs in reset", {busy, vec_rd_req, push_req, ip_restore, dlv_done, cpu_reset}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !push_req && !dlv_done && !cpu_reset, "R1", "first cycle after reset",
            {busy, push_req, dlv_done, cpu_reset}, 0);

        // table walk: R2..R7, R9 (sequence), R10 (entry 9), R11 (entry 5)
        for (int i = 0; i < NTV; i++) begin
            tv_t t = TV[i];
            int f = (t.f0 == 8'hFF) ? -1 : int'(t.f0);
            logic [31:0] eerr = (t.f0 == 8'hFF) ? (32'hC0DE_0000 | 32'(t.vec)) : 32'h0;
            logic [31:0] eaddr = BASE + (32'(t.evec) << (t.pm ? 3 : 2));
            run_case(t.pm, t.vec, t.g, f, -1, i[0], (i == 5));
            chk(got_done && !got_reset, "R7", $sformatf("entry %0d completes", i), {got_done, got_reset}, 2'b10);
            chk(nrest == (f < 0 ? 1 : 2) && rest_bad == 0, "R2", $sformatf("entry %0d restores", i), nrest, (f < 0 ? 1 : 2));
            chk(last_addr == eaddr, "R2", $sformatf("entry %0d vector addr", i), last_addr, eaddr);
            chk(dlv_vec == t.evec, (i == 5) ? "R11" : "R7", $sformatf("entry %0d vector", i), dlv_vec, t.evec);
            chk(handler_ip == t.eip && handler_cs == t.ecs, t.pm ? "R4" : "R3",
                $sformatf("entry %0d handler", i), {handler_cs, handler_ip}, {t.ecs, t.eip});
            chk(clear_if == t.eclr, t.pm ? "R4" : "R3", $sformatf("entry %0d clear_if", i), clear_if, t.eclr);
            chk(np == int'(t.enp), "R6", $sformatf("entry %0d push count", i), np, t.enp);
            chk(pw[0] == FLAGS && pw[1] == 32'(CSV) && pw[2] == SIP, "R5",
                $sformatf("entry %0d frame order", i), {pw[0], pw[2]}, {FLAGS, SIP});
            if (t.enp == 4'd4)
                chk(pw[3] == eerr, (i == 9) ? "R10" : "R6", $sformatf("entry %0d error code", i), pw[3], eerr);
        end

        // R8: second nested fault gives reset
        run_case(1'b1, 8'd13, G_I32, 0, 1, 1'b0, 1'b0);
        chk(got_reset && !got_done, "R8", "third level resets", {got_reset, got_done}, 2'b10);
        chk(nrest == 2, "R8", "restores before reset", nrest, 2);
        @(negedge clk);
        chk(!busy && !cpu_reset, "R8", "idle after reset pulse", {busy, cpu_reset}, 0);

        // R9: depth cleared by reset pulse, one fault is a double fault again
        run_case(1'b1, 8'd13, G_I32, 2, -1, 1'b0, 1'b0);
        chk(got_done && !got_reset && dlv_vec == 8'd8, "R9", "double fault after reset pulse",
            {got_done, got_reset, dlv_vec}, {2'b10, 8'd8});

        // R9: depth cleared by clean completion
        run_case(1'b0, 8'd6, G_RM, -1, -1, 1'b0, 1'b0);
        run_case(1'b0, 8'd6, G_RM, 0, -1, 1'b0, 1'b0);
        chk(got_done && !got_reset && dlv_vec == 8'd8, "R9", "double fault after completion",
            {got_done, got_reset, dlv_vec}, {2'b10, 8'd8});

        // R10: fault on final ack of an escalated attempt -> reset
        run_case(1'b1, 8'd12, G_I32, 0, 4, 1'b0, 1'b0);
        chk(got_reset && !got_done, "R10", "fault on last push of df", {got_reset, got_done}, 2'b10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule